// File: doc/BRIEF.md
# Four-Output PWM Group with Shadowed Duty Update

This block generates four pulse-width-modulated outputs from a single shared period counter. The outputs form two pairs. Each pair either drives a signal and its exact inverse, or runs as two channels with separate duty values. The counter runs in one of two ways. In edge-aligned operation it counts up and wraps. In center-aligned operation it counts up to the period value and then back down. The block also gives a one-cycle strobe at the start of each period and, in center-aligned operation, a strobe at the turning point.

Software writes the period, the four duty values and the mode bits into shadow registers through a simple write port. The block copies the shadows into the active registers only at defined update points. The first copy happens when the group is enabled, and later copies happen at every period start. In double-update mode the duty values are copied again at the center turning point, so the rising and falling halves of a center-aligned period can use different duties. The enable bit is the only field that acts at once.

Top module: `pwm_quad_group`

## Requirements
- R1: After reset all four outputs and both strobes are low. They stay low until the group is enabled.
- R2: Edge-aligned operation. The count runs 0 to P-1 and then wraps, where P is the active period. Each output is high while the count is below its duty value. The period strobe is high in the cycle where the count is 0.
- R3: Center-aligned operation, selected by control bit 1.
  - The count runs 0,1,…,P,P-1,…,1, so one period lasts 2·P cycles.
  - The period strobe is high at count 0. The midpoint strobe is high at count P.
  - The two strobes are never high together, and the midpoint strobe never lasts two cycles.
- R4: A duty value of 0 holds an output low. A duty value equal to or above the active period holds it high.
- R5: Pair mode is set by control bit 3 (pair 0, outputs 0/1) and control bit 4 (pair 1, outputs 2/3).
  - When the bit is 0, the odd output of the pair is the inverse of the even output.
  - When the bit is 1, the odd output follows its own duty value.
- R6: Register writes reach shadow registers only. The active values load on the first clock after enable is set, and this load starts the count at 0 with a period strobe. Writes made while the group is disabled do not change the outputs.
- R7: Single update (control bit 2 = 0). A duty write made during a period takes effect only at the next period start. In center-aligned operation the waveform stays symmetric for the rest of the current period.
- R8: Double update (control bit 2 = 1, center-aligned only). Duty values also load at the edge that moves the count to P. A duty written before that edge therefore governs the falling half of the same period.
- R9: A shadow write captured on the same clock edge as an update load misses that load. It takes effect at the next update point.
- R10: Clearing enable (control bit 0) forces all outputs and strobes low from the next cycle. Enabling again restarts the count at 0.
- R11: Write-port register map: address 0 = period; addresses 1–4 = duty of outputs 0–3; address 5 = control. An active period below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R11) |
| wr_data | input | CNT_W | Write data |
| pwm_o | output | 4 | PWM outputs; bits 0/1 are pair 0, bits 2/3 are pair 1 |
| prd_stb_o | output | 1 | One-cycle strobe at count 0 of each period |
| mid_stb_o | output | 1 | One-cycle strobe at the center turning point |

## Verification
The collision that matters is a duty write landing on the same clock edge as an update load, at either the midpoint or the period boundary. The bench places writes so that they are captured one edge before the midpoint load, on the midpoint load edge itself, and on the boundary load edge. It then judges on a cycle-exact waveform which half-period each new duty first governs. The expected waveform is built from the count sequence in the requirements and compared every cycle against outputs and both strobes.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
   localparam int NUM_CH   = 4;
   localparam int NUM_PAIR = NUM_CH / 2;
   localparam int ADDR_W   = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_PERIOD = 3'd0,
      A_DUTY0  = 3'd1,
      A_DUTY1  = 3'd2,
      A_DUTY2  = 3'd3,
      A_DUTY3  = 3'd4,
      A_CTRL   = 3'd5
   } reg_addr_e;

   // control register bit positions
   localparam int CTL_EN     = 0;
   localparam int CTL_CENTER = 1;
   localparam int CTL_DBL    = 2;
   localparam int CTL_INDEP0 = 3;
   localparam int CTL_BITS   = CTL_INDEP0 + NUM_PAIR;

   typedef struct packed {
      logic [NUM_PAIR-1:0] indep;
      logic                dbl;
      logic                center;
   } mode_t;
endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
   import pwm_grp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [CNT_W-1:0]              wr_data,
   input  logic                          load_all,
   input  logic                          load_mid,
   output logic                          en,
   output logic [CNT_W-1:0]              act_period,
   output logic [NUM_CH-1:0][CNT_W-1:0]  act_duty,
   output mode_t                         act_mode
);
   if (CNT_W < CTL_BITS) begin : g_bad_width
      $error("pwm_grp_regs: CNT_W too narrow for control bits");
   end

   logic [CNT_W-1:0]             sh_period;
   logic [NUM_CH-1:0][CNT_W-1:0] sh_duty;
   mode_t                        sh_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en         <= 1'b0;
         sh_period  <= '0;
         sh_duty    <= '0;
         sh_mode    <= '0;
         act_period <= '0;
         act_duty   <= '0;
         act_mode   <= '0;
      end else begin
         if (wr_en) begin
            if (wr_addr == A_PERIOD) sh_period <= wr_data;
            if (wr_addr == A_CTRL) begin
               en             <= wr_data[CTL_EN];
               sh_mode.center <= wr_data[CTL_CENTER];
               sh_mode.dbl    <= wr_data[CTL_DBL];
               sh_mode.indep  <= wr_data[CTL_BITS-1:CTL_INDEP0];
            end
            for (int c = 0; c < NUM_CH; c++) begin
               if (wr_addr == ADDR_W'(int'(A_DUTY0) + c)) sh_duty[c] <= wr_data;
            end
         end
         if (load_all) begin
            act_period <= sh_period;
            act_mode   <= sh_mode;
         end
         if (load_all || load_mid) act_duty <= sh_duty;
      end
   end
endmodule

// File: rtl/pwm_grp_counter.sv
module pwm_grp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             center,
   input  logic             dbl,
   input  logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per_eff,
   output logic             run,
   output logic             load_all,
   output logic             load_mid,
   output logic             prd_stb,
   output logic             mid_stb
);
   localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

   logic             down_q;
   logic [CNT_W-1:0] cnt_d;
   logic             down_d;
   logic             wrap;
   logic             mid_evt;

   always_comb begin
      per_eff = (act_period < MIN_PER) ? MIN_PER : act_period;
      cnt_d   = cnt + 1'b1;
      down_d  = down_q;
      wrap    = 1'b0;
      mid_evt = 1'b0;
      if (!center) begin
         if (cnt >= per_eff - 1'b1) begin
            cnt_d = '0;
            wrap  = 1'b1;
         end
      end else if (!down_q) begin
         if (cnt >= per_eff - 1'b1) begin
            cnt_d   = per_eff;
            down_d  = 1'b1;
            mid_evt = 1'b1;
         end
      end else begin
         if (cnt <= CNT_W'(1)) begin
            cnt_d  = '0;
            down_d = 1'b0;
            wrap   = 1'b1;
         end else begin
            cnt_d = cnt - 1'b1;
         end
      end
   end

   assign load_all = en & (~run | wrap);
   assign load_mid = en & run & mid_evt & dbl;
   assign prd_stb  = en & run & ~down_q & (cnt == '0);
   assign mid_stb  = en & run & center & down_q & (cnt == per_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         down_q <= 1'b0;
         run    <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         down_q <= 1'b0;
         run    <= 1'b0;
      end else if (!run) begin
         cnt    <= '0;
         down_q <= 1'b0;
         run    <= 1'b1;
      end else begin
         cnt    <= cnt_d;
         down_q <= down_d;
      end
   end
endmodule

// File: rtl/pwm_grp_pair.sv
module pwm_grp_pair #(
   parameter int CNT_W = 16
) (
   input  logic             run_en,
   input  logic             indep,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] per_eff,
   input  logic [CNT_W-1:0] duty_a,
   input  logic [CNT_W-1:0] duty_b,
   output logic [1:0]       pwm
);
   logic hi_a;
   logic hi_b;

   assign hi_a   = (duty_a >= per_eff) || (cnt < duty_a);
   assign hi_b   = (duty_b >= per_eff) || (cnt < duty_b);
   assign pwm[0] = run_en & hi_a;
   assign pwm[1] = run_en & (indep ? hi_b : ~hi_a);
endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
   import pwm_grp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] pwm_o,
   output logic              prd_stb_o,
   output logic              mid_stb_o
);
   if (CNT_W > 32) begin : g_bad_wide
      $error("pwm_quad_group: CNT_W above 32 not supported");
   end

   logic                         en;
   logic                         run;
   logic                         load_all;
   logic                         load_mid;
   logic [CNT_W-1:0]             act_period;
   logic [CNT_W-1:0]             per_eff;
   logic [CNT_W-1:0]             cnt;
   logic [NUM_CH-1:0][CNT_W-1:0] act_duty;
   mode_t                        mode;

   pwm_grp_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .load_all   (load_all),
      .load_mid   (load_mid),
      .en         (en),
      .act_period (act_period),
      .act_duty   (act_duty),
      .act_mode   (mode)
   );

   pwm_grp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (en),
      .center     (mode.center),
      .dbl        (mode.dbl),
      .act_period (act_period),
      .cnt        (cnt),
      .per_eff    (per_eff),
      .run        (run),
      .load_all   (load_all),
      .load_mid   (load_mid),
      .prd_stb    (prd_stb_o),
      .mid_stb    (mid_stb_o)
   );

   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      pwm_grp_pair #(.CNT_W(CNT_W)) u_pair (
         .run_en  (run & en),
         .indep   (mode.indep[p]),
         .cnt     (cnt),
         .per_eff (per_eff),
         .duty_a  (act_duty[2*p]),
         .duty_b  (act_duty[2*p+1]),
         .pwm     (pwm_o[2*p+1:2*p])
      );
   end
endmodule

// File: rtl/pwm_quad_group_chk.sv
module pwm_quad_group_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en,
   input logic       run,
   input logic       indep0,
   input logic [3:0] pwm,
   input logic       prd,
   input logic       mid
);
   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (pwm == 4'b0 && !prd && !mid)); // R10

   AST_PAIR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && en && !indep0) |-> (pwm[1] == !pwm[0])); // R5

   AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run) && en) |-> prd); // R6

   AST_MID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mid |=> !mid); // R3

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(prd && mid)); // R3
endmodule

bind pwm_quad_group pwm_quad_group_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .run    (run),
   .indep0 (mode.indep[0]),
   .pwm    (pwm_o),
   .prd    (prd_stb_o),
   .mid    (mid_stb_o)
);

// File: tb/pwm_quad_group_tb.sv
`timescale 1ns/1ps
module pwm_quad_group_tb;
   import pwm_grp_pkg::*;
   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [3:0]    pwm_o;
   logic          prd_stb_o;
   logic          mid_stb_o;

   always #2.5 clk = ~clk;

   pwm_quad_group #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_o(pwm_o), .prd_stb_o(prd_stb_o), .mid_stb_o(mid_stb_o)
   );

   typedef struct packed { logic [3:0] o; logic p; logic m; } exp_t;
   exp_t  eq[$];
   string tq[$];
   int    checks = 0;
   int    errs = 0;

   // monitor: one expected item per cycle
   always @(negedge clk) begin
      if (eq.size() != 0) begin
         exp_t  e;
         string t;
         e = eq.pop_front();
         t = tq.pop_front();
         checks++;
         if (pwm_o !== e.o || prd_stb_o !== e.p || mid_stb_o !== e.m) begin
            errs++;
            $display("FAIL %s: pwm=%b prd=%b mid=%b expected pwm=%b prd=%b mid=%b",
                     t, pwm_o, prd_stb_o, mid_stb_o, e.o, e.p, e.m);
         end
      end
   end

   function automatic logic hi(int c, int d, int p);
      return (d >= p) || (c < d);
   endfunction

   function automatic logic [3:0] outv(logic a0, logic b0, logic a1, logic b1, logic [1:0] ind);
      return {ind[1] ? b1 : ~a1, a1, ind[0] ? b0 : ~a0, a0};
   endfunction

   task automatic push_edge(int p, int d0, int d1, int d2, int d3, logic [1:0] ind, string t);
      for (int i = 0; i < p; i++) begin
         exp_t e;
         e.o = outv(hi(i, d0, p), hi(i, d1, p), hi(i, d2, p), hi(i, d3, p), ind);
         e.p = (i == 0);
         e.m = 1'b0;
         eq.push_back(e);
         tq.push_back(t);
      end
   endtask

   // one center period; output 0 uses u0 on the rising half and dn0 on the falling half
   task automatic push_ctr(int p, int u0, int dn0, int d1, int d2, int d3, logic [1:0] ind, string t);
      for (int i = 0; i < 2 * p; i++) begin
         exp_t e;
         int c;
         int d0;
         c  = (i <= p) ? i : 2 * p - i;
         d0 = (i < p) ? u0 : dn0;
         e.o = outv(hi(c, d0, p), hi(c, d1, p), hi(c, d2, p), hi(c, d3, p), ind);
         e.p = (i == 0);
         e.m = (i == p);
         eq.push_back(e);
         tq.push_back(t);
      end
   endtask

   task automatic push_zero(int n, string t);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e = '0;
         eq.push_back(e);
         tq.push_back(t);
      end
   endtask

   task automatic chk_idle(string t);
      checks++;
      if (pwm_o !== 4'b0 || prd_stb_o !== 1'b0 || mid_stb_o !== 1'b0) begin
         errs++;
         $display("FAIL %s: pwm=%b prd=%b mid=%b expected pwm=0000 prd=0 mid=0",
                  t, pwm_o, prd_stb_o, mid_stb_o);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cfg(int per, int d0, int d1, int d2, int d3);
      wr(A_PERIOD, W'(per));
      wr(A_DUTY0, W'(d0));
      wr(A_DUTY1, W'(d1));
      wr(A_DUTY2, W'(d2));
      wr(A_DUTY3, W'(d3));
      chk_idle("R6 shadow writes while disabled");
   endtask

   task automatic start_run(int ctl);
      wr(A_CTRL, W'(ctl));
      #1;
   endtask

   task automatic drain();
      while (eq.size() != 0) @(negedge clk);
   endtask

   task automatic stop_run();
      wr(A_CTRL, '0);
      chk_idle("R10 disable");
      @(negedge clk);
      chk_idle("R10 disable hold");
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk_idle("R1 after reset");
      end

      // R2 R4 R11: edge-aligned, pair 0 inverse, pair 1 independent
      cfg(5, 2, 0, 0, 9);
      start_run(32'h11);
      push_edge(5, 2, 0, 0, 9, 2'b10, "R2 edge");
      push_edge(5, 2, 0, 0, 9, 2'b10, "R4 edge limits");
      drain();
      stop_run();

      // R3 R5: center-aligned, pair 0 independent, pair 1 inverse
      cfg(4, 1, 3, 4, 0);
      start_run(32'h0B);
      push_ctr(4, 1, 1, 3, 4, 0, 2'b01, "R3 center");
      push_ctr(4, 1, 1, 3, 4, 0, 2'b01, "R5 pair modes");
      drain();
      stop_run();

      // R7: single update, write during rising half waits for boundary
      cfg(4, 3, 0, 0, 0);
      start_run(32'h03);
      push_ctr(4, 3, 3, 0, 0, 0, 2'b00, "R7 single update p0");
      push_ctr(4, 1, 1, 0, 0, 0, 2'b00, "R7 single update p1");
      repeat (3) @(negedge clk);
      wr(A_DUTY0, 16'd1);
      drain();
      stop_run();

      // R8 R9: double update, writes before and on the load edges
      cfg(4, 3, 0, 0, 0);
      start_run(32'h07);
      push_ctr(4, 3, 1, 0, 0, 0, 2'b00, "R8 midpoint reload");
      push_ctr(4, 2, 0, 0, 0, 0, 2'b00, "R9 write on load edge");
      push_ctr(4, 0, 0, 0, 0, 0, 2'b00, "R9 boundary collision");
      repeat (3) @(negedge clk);
      wr(A_DUTY0, 16'd1);
      wr(A_DUTY0, 16'd2);
      repeat (3) @(negedge clk);
      wr(A_DUTY0, 16'd0);
      drain();
      stop_run();

      // R11 period clamp, then R10 disable mid-run
      cfg(1, 1, 0, 0, 0);
      start_run(32'h01);
      push_edge(2, 1, 0, 0, 0, 2'b00, "R11 period clamp");
      push_edge(2, 1, 0, 0, 0, 2'b00, "R11 period clamp");
      push_edge(2, 1, 0, 0, 0, 2'b00, "R11 period clamp");
      push_zero(3, "R10 disable mid-run");
      repeat (6) @(negedge clk);
      wr(A_CTRL, '0);
      drain();
      stop_run();

      summary();
      $finish;
   end
endmodule